// File: doc/BRIEF.md
# Memory-Stage Address and Stack Unit

This block sits in the memory stage of a 32-bit five-stage pipeline. For each instruction handed over by the execute stage it works out the data-memory address, the data to write and the read or write strobe. Displacement loads and stores use a base register value plus a signed 16-bit offset. Stack pushes and pops use a dedicated stack-pointer register that the block owns. Load and pop results, along with the destination index and a write-enable, are handed on to writeback through a one-entry output register.

Both the execute-to-memory and the memory-to-writeback paths are valid/ready streams. The block accepts an instruction in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only while the output register is full and writeback holds `out_ready` low. While a result waits, its contents stay fixed until writeback accepts it. Memory strobes and stack-pointer updates happen only in a cycle where an instruction is accepted. The data memory reads combinationally, so `mem_rdata` answers `mem_addr` within the same cycle.

Top module: `mem_stack_unit`

## Requirements
- R1: After reset `sp_value` equals the parameter `SP_TOP`, `out_valid` is 0, both memory strobes are 0 and `in_ready` is 1.
- R2: An accepted load (`in_op` = 1) raises `mem_rd` with `mem_addr` = base + sign-extended offset. On the next cycle the output holds `out_wen`=1, the destination index, and the word read.
- R3: An accepted store (`in_op` = 2) raises `mem_wr` with `mem_addr` = base + sign-extended offset and `mem_wdata` = `in_store_data`. Its output entry has `out_wen`=0.
- R4: The offset is treated as two's complement: bit 15 set means a negative displacement.
- R5: An accepted push (`in_op` = 3) writes `in_store_data` at the current stack pointer. From the next cycle the stack pointer is 2 lower.
- R6: An accepted pop (`in_op` = 4) reads at stack pointer + 2. From the next cycle the stack pointer equals that address, and the word read goes to the output with `out_wen`=1.
- R7: `mem_rd` and `mem_wr` are never high together. Both stay low when nothing is accepted, and for `in_op` 0 (no memory access) or the unused codes 5 to 7.
- R8: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, no strobe is raised, the stack pointer does not move, and the output entry stays unchanged.
- R9: Every accepted instruction, including the no-access kind, produces exactly one output entry one cycle later, in order. Non-load entries carry `out_wen`=0 and data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Execute stage offers an instruction |
| in_ready | output | 1 | Block accepts the offered instruction |
| in_op | input | 3 | Operation code: 0 none, 1 load, 2 store, 3 push, 4 pop |
| in_base | input | 32 | Base register value for displacement access |
| in_offset | input | 16 | Signed displacement from the instruction |
| in_store_data | input | 32 | Register value to store or push |
| in_dst | input | 3 | Destination register index |
| mem_addr | output | 32 | Data-memory byte address |
| mem_wdata | output | 32 | Data-memory write data |
| mem_rd | output | 1 | Data-memory read strobe |
| mem_wr | output | 1 | Data-memory write strobe |
| mem_rdata | input | 32 | Data-memory read data, same cycle |
| out_valid | output | 1 | Result entry available for writeback |
| out_ready | input | 1 | Writeback takes the entry |
| out_wen | output | 1 | Entry writes a register |
| out_dst | output | 3 | Destination register index |
| out_data | output | 32 | Value for the destination register |
| sp_value | output | 32 | Current stack pointer |

## Verification
Two things can meet in one cycle: a stack operation being offered, and writeback refusing the pending entry. When they do, the push or pop must leave both the stack pointer and the memory untouched until it is finally accepted. The bench provokes this by holding `out_ready` low for several cycles under a waiting push, and by mixing pushes, pops and displacement accesses with a ready pattern that stalls every third cycle. A behavioural model with its own stack pointer and memory copy judges the strobes, address, write data, stack pointer and output entry in every cycle.

// File: rtl/msu_pkg.sv
package msu_pkg;
  typedef enum logic [2:0] {
    MOP_IDLE  = 3'd0,
    MOP_LOAD  = 3'd1,
    MOP_STORE = 3'd2,
    MOP_PUSH  = 3'd3,
    MOP_POP   = 3'd4
  } mop_e;
endpackage

// File: rtl/msu_decode.sv
module msu_decode
  import msu_pkg::*;
(
  input  logic       valid,
  input  logic       ready,
  input  logic [2:0] op,
  output logic       fire,
  output logic       is_load,
  output logic       is_store,
  output logic       is_push,
  output logic       is_pop,
  output logic       rd_req,
  output logic       wr_req
);
  always_comb begin
    fire     = valid && ready;
    is_load  = (op == MOP_LOAD);
    is_store = (op == MOP_STORE);
    is_push  = (op == MOP_PUSH);
    is_pop   = (op == MOP_POP);
    rd_req   = fire && (is_load || is_pop);
    wr_req   = fire && (is_store || is_push);
  end
endmodule

// File: rtl/msu_addr_gen.sv
module msu_addr_gen #(
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 16,
  parameter int SP_STEP = 2
) (
  input  logic [DATA_W-1:0] base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] sp,
  input  logic              use_push,
  input  logic              use_pop,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] sp_up,
  output logic [DATA_W-1:0] sp_down
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(SP_STEP);
  logic [DATA_W-1:0] off_ext;

  generate
    if (OFF_W >= DATA_W) begin : g_trunc
      assign off_ext = offset[DATA_W-1:0];
    end else begin : g_sext
      assign off_ext = {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
    end
  endgenerate

  always_comb begin
    sp_up   = sp + STEP;
    sp_down = sp - STEP;
    if (use_push)     addr = sp;
    else if (use_pop) addr = sp_up;
    else              addr = base + off_ext;
  end
endmodule

// File: rtl/msu_sp_reg.sv
module msu_sp_reg #(
  parameter int              DATA_W = 32,
  parameter logic [DATA_W-1:0] SP_TOP = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_go,
  input  logic              pop_go,
  input  logic [DATA_W-1:0] sp_up,
  input  logic [DATA_W-1:0] sp_down,
  output logic [DATA_W-1:0] sp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= SP_TOP;
    else if (push_go) sp <= sp_down;
    else if (pop_go)  sp <= sp_up;
  end
endmodule

// File: rtl/msu_wb_stage.sv
module msu_wb_stage #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              wen_in,
  input  logic [IDX_W-1:0]  dst_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_wen,
  output logic [IDX_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wen   <= 1'b0;
      out_dst   <= '0;
      out_data  <= '0;
    end else if (load_en) begin
      out_valid <= 1'b1;
      out_wen   <= wen_in;
      out_dst   <= dst_in;
      out_data  <= wen_in ? data_in : '0;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_stack_unit.sv
module mem_stack_unit
  import msu_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter int                OFF_W   = 16,
  parameter int                IDX_W   = 3,
  parameter int                SP_STEP = 2,
  parameter logic [DATA_W-1:0] SP_TOP  = 32'h0000_0FFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_base,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic [DATA_W-1:0] in_store_data,
  input  logic [IDX_W-1:0]  in_dst,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wen,
  output logic [IDX_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_data,
  output logic [DATA_W-1:0] sp_value
);
  logic fire, is_load, is_store, is_push, is_pop;
  logic [DATA_W-1:0] sp_up, sp_down;

  // Entry register frees up when empty or when writeback takes it this cycle.
  assign in_ready  = !out_valid || out_ready;
  assign mem_wdata = in_store_data;

  msu_decode u_dec (
    .valid(in_valid), .ready(in_ready), .op(in_op),
    .fire(fire), .is_load(is_load), .is_store(is_store),
    .is_push(is_push), .is_pop(is_pop),
    .rd_req(mem_rd), .wr_req(mem_wr)
  );

  msu_addr_gen #(.DATA_W(DATA_W), .OFF_W(OFF_W), .SP_STEP(SP_STEP)) u_agen (
    .base(in_base), .offset(in_offset), .sp(sp_value),
    .use_push(is_push), .use_pop(is_pop),
    .addr(mem_addr), .sp_up(sp_up), .sp_down(sp_down)
  );

  msu_sp_reg #(.DATA_W(DATA_W), .SP_TOP(SP_TOP)) u_sp (
    .clk(clk), .rst_n(rst_n),
    .push_go(fire && is_push), .pop_go(fire && is_pop),
    .sp_up(sp_up), .sp_down(sp_down), .sp(sp_value)
  );

  msu_wb_stage #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .load_en(fire),
    .wen_in(is_load || is_pop), .dst_in(in_dst), .data_in(mem_rdata),
    .out_ready(out_ready), .out_valid(out_valid), .out_wen(out_wen),
    .out_dst(out_dst), .out_data(out_data)
  );

  logic unused_store;
  assign unused_store = is_store;
endmodule

// File: rtl/msu_checker.sv
module msu_checker #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 3,
  parameter int SP_STEP = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [DATA_W-1:0] in_store_data,
  input logic [DATA_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_wen,
  input logic [IDX_W-1:0]  out_dst,
  input logic [DATA_W-1:0] out_data,
  input logic [DATA_W-1:0] sp_value
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(SP_STEP);
  logic take;
  assign take = in_valid && in_ready;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R7
  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> !mem_rd && !mem_wr); // R7
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready && !mem_rd && !mem_wr); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_dst)
      && $stable(out_wen) && $stable(sp_value)); // R8
  AST_PUSH_SITE: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd3 |-> mem_wr && mem_addr == sp_value && mem_wdata == in_store_data); // R5
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd3 |=> sp_value == $past(sp_value) - STEP); // R5
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take && in_op == 3'd4 |=> sp_value == $past(mem_addr) && out_valid && out_wen); // R6
  AST_ENTRY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R9
endmodule

bind mem_stack_unit msu_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SP_STEP(SP_STEP)) i_msu_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
  .in_store_data(in_store_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .out_valid(out_valid), .out_ready(out_ready),
  .out_wen(out_wen), .out_dst(out_dst), .out_data(out_data), .sp_value(sp_value)
);

// File: tb/test_mem_stack_unit.sv
`timescale 1ns/1ps
module test_mem_stack_unit;
  localparam logic [31:0] TOP = 32'h0000_0100;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, mem_rd, mem_wr, out_valid, out_ready = 1, out_wen;
  logic [2:0] in_op = 0, in_dst = 0, out_dst;
  logic [31:0] in_base = 0, in_store_data = 0, mem_addr, mem_wdata, mem_rdata, out_data, sp_value;
  logic [15:0] in_offset = 0;

  logic [31:0] dmem [512];
  logic [31:0] rmem [512];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_sp, m_data;
  logic m_ov, m_wen;
  logic [2:0] m_dst;

  always #4 clk = ~clk;

  mem_stack_unit #(.SP_TOP(TOP)) i_mem_stack_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_base(in_base), .in_offset(in_offset), .in_store_data(in_store_data), .in_dst(in_dst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready), .out_wen(out_wen),
    .out_dst(out_dst), .out_data(out_data), .sp_value(sp_value)
  );

  assign mem_rdata = dmem[mem_addr[9:1]];
  always @(posedge clk) if (mem_wr) dmem[mem_addr[9:1]] <= mem_wdata;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [31:0] base,
                      input logic [15:0] off, input logic [31:0] sd, input logic [2:0] dst,
                      input logic ordy, input string tag);
    logic rdy, fire, ld, pp, wr_e, rd_e;
    logic [31:0] ea, rexp;
    @(negedge clk);
    in_valid = v; in_op = op; in_base = base; in_offset = off;
    in_store_data = sd; in_dst = dst; out_ready = ordy;
    #2;
    rdy  = !m_ov || ordy;
    fire = v && rdy;
    ld   = (op == 3'd1) || (op == 3'd4);
    rd_e = fire && ld;
    wr_e = fire && (op == 3'd2 || op == 3'd3);
    ea   = (op == 3'd3) ? m_sp : (op == 3'd4) ? m_sp + 32'd2 : base + {{16{off[15]}}, off};
    chk(tag, "in_ready", {31'd0, in_ready}, {31'd0, rdy});
    chk(tag, "mem_rd", {31'd0, mem_rd}, {31'd0, rd_e});
    chk(tag, "mem_wr", {31'd0, mem_wr}, {31'd0, wr_e});
    if (rd_e || wr_e) chk(tag, "mem_addr", mem_addr, ea);
    if (wr_e) chk(tag, "mem_wdata", mem_wdata, sd);
    chk(tag, "sp", sp_value, m_sp);
    chk(tag, "out_valid", {31'd0, out_valid}, {31'd0, m_ov});
    if (m_ov) begin
      chk(tag, "out_wen", {31'd0, out_wen}, {31'd0, m_wen});
      chk(tag, "out_dst", {29'd0, out_dst}, {29'd0, m_dst});
      chk(tag, "out_data", out_data, m_data);
    end
    rexp = rmem[ea[9:1]];
    @(posedge clk);
    if (m_ov && ordy) m_ov = 0;
    if (fire) begin
      m_ov = 1; m_wen = ld; m_dst = dst; m_data = ld ? rexp : 32'd0;
      if (wr_e) rmem[ea[9:1]] = sd;
      if (op == 3'd3) m_sp = m_sp - 32'd2;
      if (op == 3'd4) m_sp = m_sp + 32'd2;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 512; i++) begin
      dmem[i] = (i * 32'h9E37_79B1) ^ 32'h0000_1234;
      rmem[i] = dmem[i];
    end
    m_sp = TOP; m_ov = 0; m_wen = 0; m_dst = 0; m_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset sp", sp_value, TOP);
    chk("R1", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "reset strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset in_ready", {31'd0, in_ready}, 32'd1);

    step(1, 3'd2, 32'h40, 16'h0004, 32'hA5A5_0001, 3'd0, 1, "R3");
    step(1, 3'd1, 32'h40, 16'h0004, 32'h0, 3'd2, 1, "R2");
    step(1, 3'd2, 32'h80, 16'hFFF8, 32'hB0B0_0002, 3'd0, 1, "R4");
    step(1, 3'd1, 32'h7C, 16'hFFFC, 32'h0, 3'd5, 1, "R4");
    step(1, 3'd3, 32'h0, 16'h0, 32'hC0C0_0003, 3'd0, 1, "R5");
    step(1, 3'd3, 32'h0, 16'h0, 32'hD0D0_0004, 3'd0, 1, "R5");
    step(1, 3'd4, 32'h0, 16'h0, 32'h0, 3'd3, 1, "R6");
    step(1, 3'd4, 32'h0, 16'h0, 32'h0, 3'd4, 1, "R6");
    step(1, 3'd0, 32'h0, 16'h0, 32'h0, 3'd1, 1, "R9");
    step(1, 3'd6, 32'h20, 16'h0, 32'h1, 3'd1, 1, "R7");
    step(0, 3'd3, 32'h0, 16'h0, 32'h2, 3'd1, 1, "R7");
    step(1, 3'd1, 32'h44, 16'h0, 32'h0, 3'd6, 0, "R8");
    for (int k = 0; k < 4; k++) step(1, 3'd3, 32'h0, 16'h0, 32'hE0E0_0005, 3'd0, 0, "R8");
    step(1, 3'd3, 32'h0, 16'h0, 32'hE0E0_0005, 3'd0, 1, "R8");
    step(1, 3'd4, 32'h0, 16'h0, 32'h0, 3'd7, 0, "R6");
    step(1, 3'd4, 32'h0, 16'h0, 32'h0, 3'd7, 1, "R8");
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op;
      string t;
      op = 3'(i % 5);
      case (op)
        3'd1: t = "R2"; 3'd2: t = "R3"; 3'd3: t = "R5"; 3'd4: t = "R6"; default: t = "R9";
      endcase
      step(1, op, 32'h100 + 32'(i * 4), 16'(i * 16'h0FF4), 32'h1000_0000 + 32'(i), 3'(i), (i % 3) != 0, t);
    end
    step(0, 3'd0, 32'h0, 16'h0, 32'h0, 3'd0, 1, "R9");
    step(0, 3'd0, 32'h0, 16'h0, 32'h0, 3'd0, 1, "R9");
    finish_run();
  end
endmodule